// File: doc/BRIEF.md
# Line Loopback and All-Ones Controller

This block sits between a T1/E1 framer and the digital side of the line interface of one channel. Its signals are dual-rail: a positive and a negative mark rail plus a clock. It picks what goes to the line driver and what goes back to the framer. The choices are normal operation, a digital loopback (transmit looped back toward the framer), a remote loopback (recovered receive data sent back out to the line), or an all-ones test pattern made of alternating marks. The pattern is timed from the master reference clock.

All-ones can be requested in two ways, and a mode input picks which one is in force. In hardware mode it is entered when the framer transmit clock stays high for more than a set number of reference-clock cycles. In software mode it comes from a per-channel register bit, or is inserted automatically while loss of signal is flagged if a second register bit allows it. The two ways are never combined. Digital loopback is suppressed while all-ones is active, and remote loopback wins when both loopbacks are requested.

Top module: `lb_ones_ctrl`

## Requirements
- R1: With no loopback and no all-ones, the line rails follow the framer transmit rails, and the framer-side clock and rails follow the recovered receive clock and rails.
- R2: In digital loopback, the framer-side clock and rails carry the framer transmit clock and rails, the line rails still carry the transmit rails, and the recovered receive inputs have no effect on any output.
- R3: In remote loopback, the line rails carry the recovered receive rails, and the framer transmit clock and rails have no effect on the line rails.
- R4: When both loopbacks are requested, remote loopback applies and the framer-side outputs carry the recovered receive clock and rails.
- R5: During all-ones, each reference-clock cycle drives exactly one line rail high. The first cycle drives the positive rail, the rails then alternate, and the framer transmit rails are ignored on the line.
- R6: In software mode, the software all-ones bit starts the pattern at once. With the automatic bit set, the pattern runs exactly while loss of signal is high.
- R7: In hardware mode, the transmit clock is passed through a two-flop synchroniser into a high-time counter. All-ones starts on the 19th reference-clock edge after the transmit clock rises, which is 17 synchronised high samples (more than HOLD_CYCLES = 16), and not on the 18th.
- R8: In hardware mode, all-ones is released on the 3rd reference-clock edge after the transmit clock goes low, because the first synchronised low sample clears the counter.
- R9: In hardware mode the software and automatic all-ones bits have no effect. In software mode, holding the transmit clock high has no effect.
- R10: While all-ones is active, a digital loopback request has no effect: the framer-side outputs carry the recovered receive clock and rails.
- R11: During and just after reset the counter is clear, so no all-ones appears in hardware mode until the hold time has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Master reference clock; times all-ones and the high-time counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_mode | input | 1 | 1 = hardware clock-high detection controls all-ones; 0 = register bits control it |
| cfg_dig_lb | input | 1 | Digital loopback request |
| cfg_rem_lb | input | 1 | Remote loopback request |
| cfg_ones | input | 1 | Software all-ones request |
| cfg_auto_ones | input | 1 | Allow all-ones while loss of signal is high (software mode) |
| los | input | 1 | Loss-of-signal flag |
| tx_clk | input | 1 | Framer transmit clock |
| tx_pos | input | 1 | Framer transmit positive rail |
| tx_neg | input | 1 | Framer transmit negative rail |
| rx_clk | input | 1 | Recovered receive clock |
| rx_pos | input | 1 | Recovered receive positive rail |
| rx_neg | input | 1 | Recovered receive negative rail |
| line_pos | output | 1 | Positive rail to line driver |
| line_neg | output | 1 | Negative rail to line driver |
| fr_clk | output | 1 | Clock toward the framer |
| fr_pos | output | 1 | Positive rail toward the framer |
| fr_neg | output | 1 | Negative rail toward the framer |

## Verification
The loopback selection and the software all-ones request act combinationally, so those results are checked one time step after the inputs change, well inside the same reference-clock cycle. The alternating marks advance one rail per reference-clock edge, so each pattern check is sampled at the falling edge after each rising edge. Hardware entry is due on the 19th rising edge after the transmit clock rises, two synchroniser flops plus 17 counted samples, and release is due on the 3rd. The bench samples at the falling edge after the 18th and the 19th edge, and after the 2nd and the 3rd, so that both sides of each boundary are seen.

// File: rtl/lb_ones_ctrl.sv
module lb_ones_ctrl #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic hw_mode,
  input  logic cfg_dig_lb,
  input  logic cfg_rem_lb,
  input  logic cfg_ones,
  input  logic cfg_auto_ones,
  input  logic los,
  input  logic tx_clk,
  input  logic tx_pos,
  input  logic tx_neg,
  input  logic rx_clk,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic line_pos,
  output logic line_neg,
  output logic fr_clk,
  output logic fr_pos,
  output logic fr_neg
);

  localparam int CW = $clog2(HOLD_CYCLES + 2);
  localparam logic [CW-1:0] FULL = CW'(HOLD_CYCLES + 1);

  logic          tx_meta, tx_sync;
  logic [CW-1:0] hi_cnt;
  logic          hw_ones, sw_ones, ones_act, alt;
  logic          dig_eff, rem_eff;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_meta <= 1'b0;
      tx_sync <= 1'b0;
    end else begin
      tx_meta <= tx_clk;
      tx_sync <= tx_meta;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)
      hi_cnt <= '0;
    else if (!tx_sync)
      hi_cnt <= '0;
    else if (hi_cnt != FULL)
      hi_cnt <= hi_cnt + 1'b1;
  end

  assign hw_ones  = (hi_cnt == FULL);
  assign sw_ones  = cfg_ones | (cfg_auto_ones & los);
  assign ones_act = hw_mode ? hw_ones : sw_ones;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)
      alt <= 1'b0;
    else
      alt <= ones_act & ~alt;
  end

  assign rem_eff = cfg_rem_lb;
  assign dig_eff = cfg_dig_lb & ~rem_eff & ~ones_act;

  always_comb begin
    if (ones_act) begin
      line_pos = ~alt;
      line_neg = alt;
    end else if (rem_eff) begin
      line_pos = rx_pos;
      line_neg = rx_neg;
    end else begin
      line_pos = tx_pos;
      line_neg = tx_neg;
    end
  end

  assign fr_clk = dig_eff ? tx_clk : rx_clk;
  assign fr_pos = dig_eff ? tx_pos : rx_pos;
  assign fr_neg = dig_eff ? tx_neg : rx_neg;

endmodule

// File: rtl/lb_ones_ctrl_chk.sv
module lb_ones_ctrl_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic hw_mode,
  input logic cfg_rem_lb,
  input logic tx_sync,
  input logic hw_ones,
  input logic ones_act,
  input logic rx_clk,
  input logic rx_pos,
  input logic rx_neg,
  input logic line_pos,
  input logic line_neg,
  input logic fr_clk,
  input logic fr_pos,
  input logic fr_neg
);

  a_r5_one_rail: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ones_act |-> (line_pos ^ line_neg));

  a_r5_alternate: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ones_act |=> (!ones_act || (line_pos == $past(line_neg) && line_neg == $past(line_pos))));

  a_r7_entry_needs_high: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(hw_ones) |-> $past(tx_sync));

  a_r8_release: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (hw_ones && !tx_sync) |=> !hw_ones);

  a_r10_dl_blocked: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ones_act |-> (fr_clk == rx_clk && fr_pos == rx_pos && fr_neg == rx_neg));

  a_r4_remote_wins: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cfg_rem_lb |-> (fr_clk == rx_clk && fr_pos == rx_pos && fr_neg == rx_neg));

  a_r9_hw_source_only: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (hw_mode && !hw_ones) |-> !ones_act);

endmodule

bind lb_ones_ctrl lb_ones_ctrl_chk u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .hw_mode(hw_mode), .cfg_rem_lb(cfg_rem_lb),
  .tx_sync(tx_sync), .hw_ones(hw_ones), .ones_act(ones_act),
  .rx_clk(rx_clk), .rx_pos(rx_pos), .rx_neg(rx_neg),
  .line_pos(line_pos), .line_neg(line_neg),
  .fr_clk(fr_clk), .fr_pos(fr_pos), .fr_neg(fr_neg)
);

// File: tb/lb_ones_ctrl_test.sv
module lb_ones_ctrl_test;

  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_mode = 1'b0, cfg_dig_lb = 1'b0, cfg_rem_lb = 1'b0, cfg_ones = 1'b0;
  logic cfg_auto_ones = 1'b0, los = 1'b0;
  logic tx_clk = 1'b0, tx_pos = 1'b0, tx_neg = 1'b0;
  logic rx_clk = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
  logic line_pos, line_neg, fr_clk, fr_pos, fr_neg;

  int n_checks = 0;
  int n_fail = 0;

  always #2 ref_clk = ~ref_clk;

  lb_ones_ctrl #(.HOLD_CYCLES(16)) uut (
    .ref_clk(ref_clk), .rst_n(rst_n), .hw_mode(hw_mode),
    .cfg_dig_lb(cfg_dig_lb), .cfg_rem_lb(cfg_rem_lb), .cfg_ones(cfg_ones),
    .cfg_auto_ones(cfg_auto_ones), .los(los),
    .tx_clk(tx_clk), .tx_pos(tx_pos), .tx_neg(tx_neg),
    .rx_clk(rx_clk), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .line_pos(line_pos), .line_neg(line_neg),
    .fr_clk(fr_clk), .fr_pos(fr_pos), .fr_neg(fr_neg)
  );

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (line_pos line_neg fr_clk fr_pos fr_neg)", req, got, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {line_pos, line_neg, fr_clk, fr_pos, fr_neg};
  endfunction

  task automatic set_tx(input logic c, input logic p, input logic n);
    tx_clk = c; tx_pos = p; tx_neg = n;
  endtask

  task automatic set_rx(input logic c, input logic p, input logic n);
    rx_clk = c; rx_pos = p; rx_neg = n;
  endtask

  task automatic idle();
    hw_mode = 0; cfg_dig_lb = 0; cfg_rem_lb = 0; cfg_ones = 0; cfg_auto_ones = 0; los = 0;
    set_tx(0, 0, 0); set_rx(0, 0, 0);
    repeat (4) @(negedge ref_clk);
  endtask

  task automatic t_reset();
    hw_mode = 1; set_tx(1, 0, 1); set_rx(1, 1, 0);
    repeat (3) @(negedge ref_clk);
    check("R11 during reset", outs(), 5'b01110);
    rst_n = 1;
    repeat (5) @(negedge ref_clk);
    check("R11 after reset", outs(), 5'b01110);
    idle();
  endtask

  task automatic t_normal();
    set_tx(1, 1, 0); set_rx(0, 0, 1); #1;
    check("R1 pattern a", outs(), 5'b10001);
    set_tx(0, 0, 1); set_rx(1, 1, 0); #1;
    check("R1 pattern b", outs(), 5'b01110);
    idle();
  endtask

  task automatic t_digital();
    cfg_dig_lb = 1; set_tx(1, 1, 0); set_rx(0, 0, 1); #1;
    check("R2 loop a", outs(), 5'b10110);
    set_rx(1, 1, 0); #1;
    check("R2 rx ignored", outs(), 5'b10110);
    set_tx(0, 0, 1); #1;
    check("R2 loop b", outs(), 5'b01001);
    idle();
  endtask

  task automatic t_remote();
    cfg_rem_lb = 1; set_rx(1, 0, 1); set_tx(1, 1, 0); #1;
    check("R3 loop a", outs(), 5'b01101);
    set_tx(0, 0, 1); #1;
    check("R3 tx ignored", outs(), 5'b01101);
    cfg_dig_lb = 1; set_tx(0, 1, 0); set_rx(1, 0, 1); #1;
    check("R4 both requested", outs(), 5'b01101);
    idle();
  endtask

  task automatic t_sw_ones();
    @(negedge ref_clk);
    cfg_ones = 1; set_tx(0, 0, 1); set_rx(1, 0, 0); #1;
    check("R5 first mark positive", outs(), 5'b10100);
    for (int i = 0; i < 4; i++) begin
      @(negedge ref_clk);
      check("R5 alternation", outs(), (i % 2 == 0) ? 5'b01100 : 5'b10100);
    end
    cfg_dig_lb = 1; set_tx(1, 1, 1); #1;
    check("R10 dig lb blocked", {fr_clk, fr_pos, fr_neg}, 3'b100);
    idle();
  endtask

  task automatic t_auto_ones();
    cfg_auto_ones = 1; set_tx(0, 1, 0); #1;
    check("R6 no los", outs(), 5'b10000);
    @(negedge ref_clk);
    los = 1; #1;
    check("R6 los mark 1", {line_pos, line_neg}, 2'b10);
    @(negedge ref_clk);
    check("R6 los mark 2", {line_pos, line_neg}, 2'b01);
    los = 0; #1;
    check("R6 los gone", {line_pos, line_neg}, 2'b10);
    idle();
  endtask

  task automatic t_hw_ones();
    hw_mode = 1; set_tx(1, 0, 0);
    repeat (18) @(posedge ref_clk);
    @(negedge ref_clk);
    check("R7 not before 19th edge", {line_pos, line_neg}, 2'b00);
    @(posedge ref_clk);
    @(negedge ref_clk);
    check("R7 on 19th edge", {line_pos, line_neg}, 2'b10);
    tx_clk = 0;
    repeat (2) @(posedge ref_clk);
    @(negedge ref_clk);
    check("R8 still on after 2 edges", line_pos ^ line_neg, 1'b1);
    @(posedge ref_clk);
    @(negedge ref_clk);
    check("R8 released on 3rd edge", {line_pos, line_neg}, 2'b00);
    idle();
  endtask

  task automatic t_mode_sel();
    hw_mode = 1; cfg_ones = 1; cfg_auto_ones = 1; los = 1; set_tx(0, 0, 1);
    repeat (3) @(negedge ref_clk);
    check("R9 sw bits ignored in hw", {line_pos, line_neg}, 2'b01);
    idle();
    set_tx(1, 0, 0);
    repeat (30) @(negedge ref_clk);
    check("R9 clock high ignored in sw", {line_pos, line_neg}, 2'b00);
    idle();
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_digital();
    t_remote();
    t_sw_ones();
    t_auto_ones();
    t_hw_ones();
    t_mode_sel();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule